// File: doc/BRIEF.md
# Manchester Line Encoder with Bit-Rate Clock

This block converts a serial NRZ data stream into a Manchester-coded line for a radio modulator's data pin. Every data bit is split into two half-bit intervals of equal length. In the first half the line carries the sampled bit. In the second half it carries the complement. A `1` therefore appears on the line as high-then-low, and a `0` as low-then-high.

The data source is paced by a bit-rate clock output. This clock is high for the first half of each bit and low for the second. The input is captured only at the edge that opens the first half. The source should therefore update `data_in` around the falling edge of `bit_clk`, so that the value is settled by the next sampling point.

The half-bit length is a parameter, counted in system clock cycles. While `en` is low, or while the block is in reset, both outputs stay low and the half-bit phase returns to "first half".

Top module: `mtx_encoder`

## Requirements
- R1: While `rst_n` is low, both `manch_out` and `bit_clk` are low. At the first rising edge of `clk` that sees `en` low, both outputs go low and the phase returns to the first half.
- R2: A bit starts at the first edge with `en` high after idle, or at the edge that ends a second half. At that edge `data_in` is sampled, and from that edge onward `manch_out` equals the sampled value for the first half.
- R3: Each half-bit lasts exactly `HALF_CYCLES` clock cycles. `manch_out` and `bit_clk` change only at half-bit boundaries.
- R4: During the second half, `manch_out` is the inverse of the sampled value. A 1 is sent as high then low; a 0 is sent as low then high.
- R5: Changes of `data_in` at any edge other than a bit-start edge have no effect on `manch_out`.
- R6: `bit_clk` is high (1) throughout the first half of every bit and low (0) throughout the second half.
- R7: While `en` stays high, bits follow each other with no gap. The bit period is `2*HALF_CYCLES` cycles, and the next sample is taken at the edge that ends the previous second half.
- R8: Dropping `en` in the middle of a bit abandons that bit: both outputs are low after the next edge. Raising `en` again starts a new bit with a first half and a fresh sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Encoder enable; low holds both outputs low |
| data_in | input | 1 | NRZ data bit from the source |
| manch_out | output | 1 | Manchester-coded line |
| bit_clk | output | 1 | Bit-rate clock: high in the first half, low in the second |

## Verification
The bench builds the encoder with `HALF_CYCLES` set to 3. This odd, short half-bit keeps every bit at six cycles, so long back-to-back bursts, aborts part-way through both halves, and input glitches on every non-sampling edge all fit into a short run. Setting the value to 3 rather than a power of two also exercises a counter wrap point that is not an all-ones value.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
   typedef enum logic {
      PH_FIRST  = 1'b0,
      PH_SECOND = 1'b1
   } mtx_phase_e;
endpackage

// File: rtl/mtx_half_timer.sv
module mtx_half_timer #(
   parameter int unsigned HALF_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int unsigned CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYCLES - 1);

   generate
      if (HALF_CYCLES < 1) begin : g_bad_len
         $error("mtx_half_timer: HALF_CYCLES must be at least 1");
      end

      if (HALF_CYCLES == 1) begin : g_single
         // Every cycle closes a half-bit.
         assign tick = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (!run)             cnt <= '0;
            else if (restart || tick)  cnt <= '0;
            else                       cnt <= cnt + 1'b1;
         end

         assign tick = (cnt == LAST);

         // R3
         restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && restart) |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/mtx_phase_ctrl.sv
module mtx_phase_ctrl
   import mtx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       din,
   output logic       start_bit,
   output logic       to_second,
   output logic       held,
   output logic       active,
   output mtx_phase_e phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   active <= 1'b0;
      else          active <= en;
   end

   assign start_bit = en && (!active || (tick && phase == PH_SECOND));
   assign to_second = en && active && tick && (phase == PH_FIRST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_FIRST;
         held  <= 1'b0;
      end else if (!en) begin
         phase <= PH_FIRST;
         held  <= 1'b0;
      end else if (start_bit) begin
         phase <= PH_FIRST;
         held  <= din;
      end else if (to_second) begin
         phase <= PH_SECOND;
      end
   end

   // R5
   held_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !start_bit) |=> $stable(held));

   // R7
   phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && active && tick) |=> (phase != $past(phase)));
endmodule

// File: rtl/mtx_line_coder.sv
module mtx_line_coder (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic start_bit,
   input  logic to_second,
   input  logic din,
   input  logic held,
   output logic line,
   output logic bclk
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line <= 1'b0;
         bclk <= 1'b0;
      end else if (!en) begin
         line <= 1'b0;
         bclk <= 1'b0;
      end else if (start_bit) begin
         line <= din;
         bclk <= 1'b1;
      end else if (to_second) begin
         line <= ~held;
         bclk <= 1'b0;
      end
   end

   // R1
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!line && !bclk));

   // R2
   first_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_bit |=> (line == $past(din)) && bclk);

   // R4
   second_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      to_second |=> (line == !$past(held)) && !bclk);

   // R3
   half_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !start_bit && !to_second) |=> ($stable(line) && $stable(bclk)));
endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder
   import mtx_pkg::*;
#(
   parameter int unsigned HALF_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic data_in,
   output logic manch_out,
   output logic bit_clk
);
   logic       tick;
   logic       start_bit;
   logic       to_second;
   logic       held;
   logic       active;
   mtx_phase_e phase;

   mtx_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en),
      .restart (start_bit),
      .tick    (tick)
   );

   mtx_phase_ctrl u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .tick      (tick),
      .din       (data_in),
      .start_bit (start_bit),
      .to_second (to_second),
      .held      (held),
      .active    (active),
      .phase     (phase)
   );

   mtx_line_coder u_coder (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .start_bit (start_bit),
      .to_second (to_second),
      .din       (data_in),
      .held      (held),
      .line      (manch_out),
      .bclk      (bit_clk)
   );

   // R6
   bclk_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (bit_clk == (phase == PH_FIRST)));
endmodule

// File: tb/mtx_encoder_test.sv
module mtx_encoder_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF = 3;

   typedef struct {
      logic  line;
      logic  bclk;
      string line_tag;
      string bclk_tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic data_in = 1'b0;
   logic manch_out;
   logic bit_clk;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mtx_encoder #(.HALF_CYCLES(HALF)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .data_in   (data_in),
      .manch_out (manch_out),
      .bit_clk   (bit_clk)
   );

   task automatic push(input logic l, input logic b, input string lt, input string bt);
      exp_t e;
      e.line = l; e.bclk = b; e.line_tag = lt; e.bclk_tag = bt;
      exp_q.push_back(e);
   endtask

   // Called at a falling edge; the next rising edge opens the bit.
   // ncyc < 2*HALF aborts the bit after that many cycles.
   task automatic send_bit(input logic b, input bit glitch, input int ncyc, input string tag);
      en = 1'b1;
      data_in = b;
      for (int i = 0; i < ncyc; i++) begin
         if (i < HALF) push(b, 1'b1, {"R2 ", tag}, "R3 R6");
         else          push(~b, 1'b0, {"R4 ", tag}, "R3 R6");
      end
      for (int i = 1; i <= ncyc; i++) begin
         @(negedge clk);
         if (glitch && i < ncyc) data_in = ~data_in;
      end
   endtask

   task automatic idle(input int n, input string tag);
      en = 1'b0;
      data_in = 1'b1;
      for (int i = 0; i < n; i++) push(1'b0, 1'b0, tag, tag);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Monitor: compares one expected item per cycle, just after each edge.
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            checks++;
            if (manch_out !== e.line) begin
               errors++;
               $display("FAIL %s: manch_out actual %b expected %b", e.line_tag, manch_out, e.line);
            end
            checks++;
            if (bit_clk !== e.bclk) begin
               errors++;
               $display("FAIL %s: bit_clk actual %b expected %b", e.bclk_tag, bit_clk, e.bclk);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset holds outputs low even with en high
      en = 1'b1;
      data_in = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (manch_out !== 1'b0 || bit_clk !== 1'b0) begin
         errors++;
         $display("FAIL R1: reset outputs actual %b%b expected 00", manch_out, bit_clk);
      end
      en = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      idle(3, "R1");

      // Single bits of each value
      send_bit(1'b1, 1'b0, 2*HALF, "single");
      idle(2, "R1");
      send_bit(1'b0, 1'b0, 2*HALF, "single");
      idle(2, "R1");

      // R7: back-to-back burst
      send_bit(1'b1, 1'b0, 2*HALF, "R7");
      send_bit(1'b1, 1'b0, 2*HALF, "R7");
      send_bit(1'b0, 1'b0, 2*HALF, "R7");
      send_bit(1'b0, 1'b0, 2*HALF, "R7");
      send_bit(1'b1, 1'b0, 2*HALF, "R7");
      send_bit(1'b0, 1'b0, 2*HALF, "R7");

      // R5: data_in toggles at every non-sampling edge
      send_bit(1'b1, 1'b1, 2*HALF, "R5");
      send_bit(1'b0, 1'b1, 2*HALF, "R5");
      send_bit(1'b1, 1'b1, 2*HALF, "R5");
      idle(2, "R1");

      // R8: abort in the first half, then in the second half
      send_bit(1'b1, 1'b0, 2, "R8");
      idle(1, "R8");
      send_bit(1'b0, 1'b0, 2*HALF, "R8");
      send_bit(1'b1, 1'b0, HALF + 1, "R8");
      idle(2, "R8");
      send_bit(1'b1, 1'b0, 2*HALF, "R8");
      send_bit(1'b0, 1'b1, 2*HALF, "R8");
      idle(3, "R1");

      wait (exp_q.size() == 0);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule